// File: doc/BRIEF.md
# Serial Configuration Register Bank for a Modem Front End

This block holds the digital control state of a broadband modem front end and is loaded over a simple serial port. A host frames each transaction with an active-low select. The host sends an instruction byte, which holds a read/write flag and a seven-bit address, and then one data byte. Each bit is sampled on the rising edge of the serial clock. The serial pins are oversampled by the system clock. Read data leaves on a separate output together with an output-enable, so the same logic serves a four-wire link or a three-wire link in which the host ties data-in and data-out together through that enable.

Four registers are implemented. The control register holds the run-time bit-order select and a self-clearing soft-reset trigger. Two power-down masks exist, and an external pin chooses which of them drives the single power-down vector seen by the analog blocks. The clock register is decoded into a transmit multiplier, a receive multiplier and divider, a transmit sampling-edge select and an ADC clock-source select, and it is screened for settings that cannot be used.

Top module: `spi_cfg_bank`

## Requirements
- R1: A transaction is framed by `spi_csn` low. The instruction byte comes first: its bit 7 is 1 for a read and 0 for a write, and its bits 6:0 are the address. The data byte follows. Inputs are sampled on rising `spi_sclk`. During the data byte of a read, `spi_sdo_en` is high and `spi_sdo` carries the addressed register. Each data bit is valid before the rising edge on which the host samples it.
- R2: Bit 6 of register 0 sets the order of every byte on the wire: 1 sends LSB first, 0 sends MSB first. After reset the order is MSB first.
- R3: A new value of the order bit applies from the next transaction onward. The transaction that writes the bit completes in the previous order.
- R4: The reset values are register 0 = 0x00, register 1 = 0x00, register 2 = 0xFF and register 3 = 0x1A. Writing register 0 with bit 5 set returns all registers to these values. The exception is bit 6, which takes the value carried in that same byte.
- R5: After a soft reset is triggered, `soft_rst` is high for exactly RST_CYCLES system clocks. Register 0 bit 5 reads 1 for that whole time and reads 0 afterwards. Writes that arrive while `soft_rst` is high change nothing.
- R6: One clock after the inputs change, `pd_vec` equals register 1 when `pd_pin` is low and register 2 when it is high. The bit meanings are: 0 receive filter and coarse gain, 1 ADC and fine gain, 2 receive reference, 3 interpolators, 4 DAC, 5 transmit PLL, 6 receive PLL, 7 regulator.
- R7: `pll_a_mult` equals 1, 2, 4 or 8 for register 3 bits 1:0 = 00, 01, 10 or 11. All decoded outputs follow register 3 one clock later.
- R8: `pll_b_mult` is 3, 4 or 6 for register 3 bits 5:4 = 00, 01 or 10. `pll_b_div` is 2, 4 or 1 for bits 3:2 = 00, 01 or 10. Code 11 in either field gives 0.
- R9: `tx_fall_edge` follows register 3 bit 7, where 1 means the transmit port samples on the falling edge. `adc_clk_pllb` follows register 3 bit 6.
- R10: `clk_cfg_bad` is high in two cases. The first is when either field of R8 holds code 11. The second is when register 3 bit 6 is 0 and the transmit multiplier is not 4 or the receive ratio multiplier/divider is not 4.
- R11: A frame that ends before the sixteenth bit writes nothing. Addresses 4 and above read as 0 and ignore writes. In register 0, all bits other than 6 and 5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Active-low transaction frame |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial read data to host |
| spi_sdo_en | output | 1 | High while `spi_sdo` is driven |
| pd_pin | input | 1 | Power-down mask select |
| pd_vec | output | 8 | Effective power-down vector |
| pll_a_mult | output | 4 | Transmit PLL multiplier |
| pll_b_mult | output | 3 | Receive PLL multiplier, 0 if reserved |
| pll_b_div | output | 3 | Receive PLL divider, 0 if reserved |
| adc_clk_pllb | output | 1 | ADC clock taken from the receive PLL |
| tx_fall_edge | output | 1 | Transmit port samples on falling edge |
| clk_cfg_bad | output | 1 | Clock register holds an unusable setting |
| soft_rst | output | 1 | Soft-reset pulse |

## Verification
Two functions can act in the same cycle. The power-down select can switch while a serial write is committing a new value into a mask register. The bench provokes this by toggling `pd_pin` on every clock across a whole write of register 1. After each edge, the vector must be register 2 when the pin is high, and either the old or the new register 1 value when the pin is low. Once the frame has ended it must be exactly the new value. A second overlap is a write that lands inside the soft-reset pulse, which is judged by reading the target register back after the pulse.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int BYTE_W    = 8;
  localparam int INSTR_AW  = 7;

  localparam int REG_CTRL  = 0;
  localparam int REG_PD_LO = 1;
  localparam int REG_PD_HI = 2;
  localparam int REG_CLK   = 3;

  localparam int CTRL_RST_BIT = 5;
  localparam int CTRL_LSB_BIT = 6;

  typedef struct packed {
    logic [3:0] a_mult;
    logic [2:0] b_mult;
    logic [2:0] b_div;
    logic       adc_pllb;
    logic       tx_fall;
    logic       bad;
  } clk_dec_t;

  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    case (idx)
      REG_PD_HI: reg_default = 8'hFF;
      REG_CLK:   reg_default = 8'h1A;
      default:   reg_default = 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
    if (idx == REG_CTRL)
      reg_wmask = (8'h1 << CTRL_LSB_BIT) | (8'h1 << CTRL_RST_BIT);
    else
      reg_wmask = 8'hFF;
  endfunction

  function automatic clk_dec_t decode_clk(input logic [BYTE_W-1:0] r);
    clk_dec_t d;
    d.a_mult = 4'd1 << r[1:0];
    case (r[5:4])
      2'b00:   d.b_mult = 3'd3;
      2'b01:   d.b_mult = 3'd4;
      2'b10:   d.b_mult = 3'd6;
      default: d.b_mult = 3'd0;
    endcase
    case (r[3:2])
      2'b00:   d.b_div = 3'd2;
      2'b01:   d.b_div = 3'd4;
      2'b10:   d.b_div = 3'd1;
      default: d.b_div = 3'd0;
    endcase
    d.adc_pllb = r[6];
    d.tx_fall  = r[7];
    d.bad = (r[5:4] == 2'b11) || (r[3:2] == 2'b11) ||
            (!r[6] && ((r[1:0] != 2'b10) || (r[5:4] != 2'b01) || (r[3:2] != 2'b10)));
    return d;
  endfunction

endpackage

// File: rtl/spi_cfg_serial.sv
module spi_cfg_serial
  import spi_cfg_pkg::*;
#(
  parameter int AW = INSTR_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csn,
  input  logic              sdi,
  input  logic              lsb_cfg,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en
);

  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [2:0] sclk_q;
  logic [2:0] csn_q;
  logic [1:0] sdi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      csn_q  <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      csn_q  <= {csn_q[1:0], csn};
      sdi_q  <= {sdi_q[0], sdi};
    end
  end

  logic rise, active, start;
  assign rise   = sclk_q[1] & ~sclk_q[2];
  assign active = ~csn_q[1];
  assign start  = ~csn_q[1] & csn_q[2];

  logic              lsb_act;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, sh_nx, obuf;
  logic              is_rd, load_pend, rd_phase;

  assign sh_nx = lsb_act ? {sdi_q[1], sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], sdi_q[1]};

  // R1 R2 R3 R11: framing, per-frame order latch, abort handling
  always_ff @(posedge clk) begin
    if (rst) begin
      lsb_act   <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      obuf      <= '0;
      is_rd     <= 1'b0;
      load_pend <= 1'b0;
      rd_phase  <= 1'b0;
      addr      <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
    end else begin
      wr_en     <= 1'b0;
      load_pend <= 1'b0;
      if (!active) begin
        cnt      <= '0;
        is_rd    <= 1'b0;
        rd_phase <= 1'b0;
      end else begin
        if (start) lsb_act <= lsb_cfg;
        if (rise && cnt != CNT_W'(FRAME_BITS)) begin
          sh  <= sh_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(BYTE_W - 1)) begin
            is_rd     <= sh_nx[BYTE_W-1];
            addr      <= sh_nx[AW-1:0];
            load_pend <= sh_nx[BYTE_W-1];
          end
          if (cnt == CNT_W'(FRAME_BITS - 1) && !is_rd) begin
            wr_en   <= 1'b1;
            wr_data <= sh_nx;
          end
          if (rd_phase)
            obuf <= lsb_act ? (obuf >> 1) : (obuf << 1);
        end
        if (load_pend) begin
          obuf     <= rd_data;
          rd_phase <= 1'b1;
        end
      end
    end
  end

  assign sdo    = rd_phase & (lsb_act ? obuf[0] : obuf[BYTE_W-1]);
  assign sdo_en = rd_phase;

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int NREGS      = 4,
  parameter int AW         = INSTR_AW,
  parameter int RST_CYCLES = 1000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [BYTE_W-1:0]            rd_data,
  output logic [NREGS-1:0][BYTE_W-1:0] regs_all,
  output logic                         busy
);

  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [BYTE_W-1:0] regs [NREGS];
  logic [RC_W-1:0]   rcnt;
  logic              in_range;

  assign in_range = (int'(addr) < NREGS);

  // R4 R5 R11: defaults, self-clearing soft reset, write masking
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREGS; k++) regs[k] <= reg_default(k);
      busy <= 1'b0;
      rcnt <= '0;
    end else if (busy) begin
      if (rcnt == '0) begin
        busy                     <= 1'b0;
        regs[REG_CTRL][CTRL_RST_BIT] <= 1'b0;
      end else begin
        rcnt <= rcnt - 1'b1;
      end
    end else if (wr_en && in_range) begin
      if (int'(addr) == REG_CTRL && wr_data[CTRL_RST_BIT]) begin
        for (int k = 1; k < NREGS; k++) regs[k] <= reg_default(k);
        regs[REG_CTRL] <= (reg_default(REG_CTRL) & ~(8'h1 << CTRL_LSB_BIT))
                        | (wr_data & (8'h1 << CTRL_LSB_BIT))
                        | (8'h1 << CTRL_RST_BIT);
        busy <= 1'b1;
        rcnt <= RC_W'(RST_CYCLES - 1);
      end else begin
        regs[addr[$clog2(NREGS)-1:0]] <= wr_data & reg_wmask(int'(addr));
      end
    end
  end

  assign rd_data = in_range ? regs[addr[$clog2(NREGS)-1:0]] : '0;

  for (genvar g = 0; g < NREGS; g++) begin : g_flat
    assign regs_all[g] = regs[g];
  end

endmodule

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              pd_pin,
  input  logic [BYTE_W-1:0] pd_lo,
  input  logic [BYTE_W-1:0] pd_hi,
  input  logic [BYTE_W-1:0] clk_reg,
  output logic [BYTE_W-1:0] pd_vec,
  output clk_dec_t          dec
);

  // R6 R7 R8 R9 R10: one registered stage, refilled every cycle from state
  always_ff @(posedge clk) begin
    pd_vec <= pd_pin ? pd_hi : pd_lo;
    dec    <= decode_clk(clk_reg);
  end

endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
#(
  parameter int NREGS      = 4,
  parameter int RST_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sclk,
  input  logic       spi_csn,
  input  logic       spi_sdi,
  output logic       spi_sdo,
  output logic       spi_sdo_en,
  input  logic       pd_pin,
  output logic [7:0] pd_vec,
  output logic [3:0] pll_a_mult,
  output logic [2:0] pll_b_mult,
  output logic [2:0] pll_b_div,
  output logic       adc_clk_pllb,
  output logic       tx_fall_edge,
  output logic       clk_cfg_bad,
  output logic       soft_rst
);

  logic [INSTR_AW-1:0]          addr;
  logic                         wr_en;
  logic [BYTE_W-1:0]            wr_data, rd_data;
  logic [NREGS-1:0][BYTE_W-1:0] regs_all;
  clk_dec_t                     dec;

  spi_cfg_serial #(.AW(INSTR_AW)) i_serial (
    .clk     (clk),
    .rst     (rst),
    .sclk    (spi_sclk),
    .csn     (spi_csn),
    .sdi     (spi_sdi),
    .lsb_cfg (regs_all[REG_CTRL][CTRL_LSB_BIT]),
    .rd_data (rd_data),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sdo     (spi_sdo),
    .sdo_en  (spi_sdo_en)
  );

  spi_cfg_regs #(
    .NREGS      (NREGS),
    .AW         (INSTR_AW),
    .RST_CYCLES (RST_CYCLES)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .regs_all (regs_all),
    .busy     (soft_rst)
  );

  spi_cfg_decode i_decode (
    .clk     (clk),
    .pd_pin  (pd_pin),
    .pd_lo   (regs_all[REG_PD_LO]),
    .pd_hi   (regs_all[REG_PD_HI]),
    .clk_reg (regs_all[REG_CLK]),
    .pd_vec  (pd_vec),
    .dec     (dec)
  );

  assign pll_a_mult   = dec.a_mult;
  assign pll_b_mult   = dec.b_mult;
  assign pll_b_div    = dec.b_div;
  assign adc_clk_pllb = dec.adc_pllb;
  assign tx_fall_edge = dec.tx_fall;
  assign clk_cfg_bad  = dec.bad;

endmodule

// File: rtl/spi_cfg_bank_chk.sv
module spi_cfg_bank_chk #(
  parameter int NREGS = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    pd_pin,
  input logic [7:0]              pd_vec,
  input logic [NREGS-1:0][7:0]   regs_all,
  input logic                    soft_rst,
  input logic                    spi_csn,
  input logic                    spi_sdo_en,
  input logic                    wr_en,
  input logic                    clk_cfg_bad
);

  // R6
  pd_track_chk: assert property (@(posedge clk) disable iff (rst)
    pd_vec == $past(pd_pin ? regs_all[2] : regs_all[1]));

  // R5
  rst_flag_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> regs_all[0][5]);

  // R5
  rst_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && $past(soft_rst)) |-> $stable(regs_all));

  // R5
  rst_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(soft_rst) |-> !regs_all[0][5]);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
      |-> (!wr_en && !spi_sdo_en));

  // R10
  bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(regs_all[3][6]) && ($past(regs_all[3][1:0]) != 2'b10)) |-> clk_cfg_bad);

endmodule

bind spi_cfg_bank spi_cfg_bank_chk #(.NREGS(NREGS)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .pd_pin      (pd_pin),
  .pd_vec      (pd_vec),
  .regs_all    (regs_all),
  .soft_rst    (soft_rst),
  .spi_csn     (spi_csn),
  .spi_sdo_en  (spi_sdo_en),
  .wr_en       (wr_en),
  .clk_cfg_bad (clk_cfg_bad)
);

// File: tb/test_spi_cfg_bank.sv
module test_spi_cfg_bank;

  localparam int RSTC = 1000;
  localparam int H    = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, sclk, csn, sdi, sdo, sdo_en, pd_pin;
  logic [7:0] pd_vec;
  logic [3:0] a_mult;
  logic [2:0] b_mult, b_div;
  logic       adc_pllb, tx_fall, bad, soft_rst;

  spi_cfg_bank #(.NREGS(4), .RST_CYCLES(RSTC)) i_spi_cfg_bank (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_en(sdo_en), .pd_pin(pd_pin), .pd_vec(pd_vec),
    .pll_a_mult(a_mult), .pll_b_mult(b_mult), .pll_b_div(b_div),
    .adc_clk_pllb(adc_pllb), .tx_fall_edge(tx_fall), .clk_cfg_bad(bad),
    .soft_rst(soft_rst)
  );

  int n_chk = 0, n_fail = 0, hi_cnt = 0;
  bit lsb_m = 1'b0, done = 1'b0;

  always @(posedge clk) if (soft_rst === 1'b1) hi_cnt <= hi_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, output logic [7:0] q);
    logic [7:0] ib, b;
    int j;
    ib = {rd, a};
    q = '0;
    csn = 1'b0;
    tick(H);
    for (int i = 0; i < nbits; i++) begin
      j = i % 8;
      b = (i < 8) ? ib : d;
      sdi = lsb_m ? b[j] : b[7-j];
      tick(H);
      if (i >= 8 && rd) begin
        if (i == 8) chk(sdo_en === 1'b1, "R1 sdo_en", int'(sdo_en), 1);
        if (lsb_m) q[j] = sdo; else q[7-j] = sdo;
      end
      sclk = 1'b1;
      tick(H);
      sclk = 1'b0;
    end
    tick(H);
    csn = 1'b1;
    tick(2 * H);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] q;
    xfer(1'b0, a, d, 16, q);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] q);
    xfer(1'b1, a, 8'h00, 16, q);
  endtask

  task automatic check_clk(input logic [7:0] v);
    int l, m, n;
    bit e_bad;
    l = 1 << v[1:0];
    m = (v[5:4] == 0) ? 3 : (v[5:4] == 1) ? 4 : (v[5:4] == 2) ? 6 : 0;
    n = (v[3:2] == 0) ? 2 : (v[3:2] == 1) ? 4 : (v[3:2] == 2) ? 1 : 0;
    e_bad = (m == 0) || (n == 0) || (!v[6] && !(l == 4 && m == 4 * n));
    chk(int'(a_mult) == l, "R7 a_mult", int'(a_mult), l);
    chk(int'(b_mult) == m, "R8 b_mult", int'(b_mult), m);
    chk(int'(b_div) == n, "R8 b_div", int'(b_div), n);
    chk(tx_fall == v[7] && adc_pllb == v[6], "R9 edge/src",
        int'({tx_fall, adc_pllb}), int'(v[7:6]));
    chk(bad == e_bad, "R10 bad", int'(bad), int'(e_bad));
  endtask

  initial begin
    logic [7:0] q;
    logic [7:0] pats [6];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    rst = 1'b1; csn = 1'b1; sclk = 1'b0; sdi = 1'b0; pd_pin = 1'b0;
    tick(5);
    rst = 1'b0;
    tick(3);

    // R4 reset state
    chk(pd_vec == 8'h00, "R4 pd_vec", int'(pd_vec), 0);
    chk(soft_rst == 1'b0 && sdo_en == 1'b0, "R4 idle", int'({soft_rst, sdo_en}), 0);
    check_clk(8'h1A);
    rd(7'd0, q); chk(q == 8'h00, "R4 reg0", int'(q), 8'h00);
    rd(7'd1, q); chk(q == 8'h00, "R4 reg1", int'(q), 8'h00);
    rd(7'd2, q); chk(q == 8'hFF, "R4 reg2", int'(q), 8'hFF);
    rd(7'd3, q); chk(q == 8'h1A, "R4 reg3", int'(q), 8'h1A);

    // R1 write/read sweep, R6 mask select
    foreach (pats[k]) begin
      wr(7'd1, pats[k]);
      wr(7'd2, ~pats[k]);
      rd(7'd1, q); chk(q == pats[k], "R1 reg1", int'(q), int'(pats[k]));
      rd(7'd2, q); chk(q == ~pats[k], "R1 reg2", int'(q), int'(~pats[k]));
      pd_pin = 1'b0; tick(2);
      chk(pd_vec == pats[k], "R6 pin low", int'(pd_vec), int'(pats[k]));
      pd_pin = 1'b1; tick(2);
      chk(pd_vec == ~pats[k], "R6 pin high", int'(pd_vec), int'(~pats[k]));
    end
    pd_pin = 1'b0;

    // R7 R8 R9 R10 exhaustive clock register sweep
    for (int v = 0; v < 256; v++) begin
      wr(7'd3, 8'(v));
      tick(2);
      check_clk(8'(v));
      if (v % 37 == 0) begin
        rd(7'd3, q); chk(q == 8'(v), "R1 reg3", int'(q), v);
      end
    end

    // R11 range, masking, abort
    rd(7'd4, q); chk(q == 8'h00, "R11 addr4", int'(q), 0);
    rd(7'd127, q); chk(q == 8'h00, "R11 addr127", int'(q), 0);
    wr(7'd5, 8'hFF);
    rd(7'd5, q); chk(q == 8'h00, "R11 addr5 write", int'(q), 0);
    wr(7'd0, 8'h9F);
    rd(7'd0, q); chk(q == 8'h00, "R11 reg0 mask", int'(q), 0);
    wr(7'd1, 8'h33);
    xfer(1'b0, 7'd1, 8'hCC, 12, q);
    rd(7'd1, q); chk(q == 8'h33, "R11 abort", int'(q), 8'h33);

    // R2 R3 bit order
    wr(7'd0, 8'h40);
    lsb_m = 1'b1;
    rd(7'd0, q); chk(q == 8'h40, "R3 order next frame", int'(q), 8'h40);
    rd(7'd1, q); chk(q == 8'h33, "R2 lsb read", int'(q), 8'h33);
    wr(7'd2, 8'h81);
    rd(7'd2, q); chk(q == 8'h81, "R2 lsb write", int'(q), 8'h81);
    wr(7'd0, 8'h00);
    lsb_m = 1'b0;
    rd(7'd0, q); chk(q == 8'h00, "R3 back to msb", int'(q), 0);

    // R4 R5 soft reset with order kept
    wr(7'd1, 8'h55);
    wr(7'd3, 8'h80);
    hi_cnt = 0;
    wr(7'd0, 8'h60);
    chk(soft_rst == 1'b1, "R5 pulse high", int'(soft_rst), 1);
    lsb_m = 1'b1;
    rd(7'd0, q); chk(q == 8'h60, "R5 flag reads 1", int'(q), 8'h60);
    wr(7'd1, 8'h77);
    while (soft_rst) tick(1);
    tick(1);
    chk(hi_cnt == RSTC, "R5 pulse length", hi_cnt, RSTC);
    rd(7'd0, q); chk(q == 8'h40, "R4 order kept", int'(q), 8'h40);
    rd(7'd1, q); chk(q == 8'h00, "R5 write ignored", int'(q), 0);
    rd(7'd3, q); chk(q == 8'h1A, "R4 clk default", int'(q), 8'h1A);

    // R6 pin toggling while a mask write commits
    wr(7'd2, 8'hF0);
    wr(7'd1, 8'h0F);
    fork
      wr(7'd1, 8'h3C);
      begin
        bit p;
        p = 1'b0;
        repeat (300) begin
          p = ~p;
          pd_pin = p;
          tick(1);
          chk(p ? (pd_vec == 8'hF0) : (pd_vec == 8'h0F || pd_vec == 8'h3C),
              "R6 overlap", int'(pd_vec), p ? 8'hF0 : 8'h3C);
        end
      end
    join
    pd_pin = 1'b0;
    tick(2);
    chk(pd_vec == 8'h3C, "R6 after overlap", int'(pd_vec), 8'h3C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule